// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block answers on a two-wire (I2C) bus as a small byte-addressed serial EEPROM whose storage lives in registers inside the block. A fast system clock oversamples the bus clock and data lines. The block detects start and stop conditions and checks the address byte against a fixed device-type code and the select straps. It then takes a word address and serves writes of one byte up to a full page, plus current-address, random and sequential reads.

The data line is open-drain. The block never drives it high; `sda_oe` high means the block pulls the line low. A parameter chooses a 256-byte or a 512-byte array. In the larger size, one address-byte bit picks which 256-byte half the word address refers to. Received write bytes are held in a page buffer and reach the array only when a stop ends the transfer. After that the block stays busy for a parameterised number of clocks and ignores its own address.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: The block acknowledges an address byte only if its bits 7..4 equal 1010 and the select bits match the straps. In the 256-byte build the select bits are bits 3..1, compared with `strap_i[2:0]`. Any other address byte gets no acknowledge, and the block stays silent until the next start or stop.
- R2: In the 512-byte build (`BIG`=1), only address bits 3..2 are compared with `strap_i[2:1]`. Bit 1 becomes bit 8 of the word address taken in that transfer (0 selects 0x000–0x0FF, 1 selects 0x100–0x1FF).
- R3: Acknowledge means `sda_oe` is high during the ninth clock. It is given for a matching address byte, for the word address and for each accepted write byte. `sda_oe` only rises while SCL is low, and it is low whenever no transfer is in progress.
- R4: Address bit 0 selects direction (0 write, 1 read). A write transfer carrying a word address and then a repeated start with a read address returns the byte stored at that word address.
- R5: A page holds 8 bytes (256-byte build) or 16 bytes (512-byte build). Successive write bytes advance only the in-page address bits and wrap to the page start. A later byte that lands on an already filled slot replaces it.
- R6: Buffered write bytes reach the array only on a stop. A repeated start discards them and starts no busy period.
- R7: After a stop that commits data, the block refuses its address (no acknowledge) for `BUSY_CYCLES` clocks.
- R8: While `wp_i` is high, the address and word-address bytes are still acknowledged, but write bytes are not. Nothing is stored and no busy period follows.
- R9: Reads advance the address after each byte and roll over across the whole array (0xFF→0x00 or 0x1FF→0x000). A master acknowledge after bit 0 fetches the next byte, and a master not-acknowledge ends the read.
- R10: A read with no word address starts at the address following the last byte read.
- R11: After reset the array holds all zeros and `sda_oe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | High pulls the data line low |
| strap_i | input | 3 | Device select straps |
| wp_i | input | 1 | Write protect; high blocks every store |

## Verification
The hardest state to reach from the ports is the busy window right after a commit. The bench checks it by issuing an address poll immediately after the stop of the first page write, which completes well inside the busy count. Page wrap with overwrite needs a burst longer than one page: ten bytes into an 8-byte page and seventeen into a 16-byte page, then a read that covers the whole page. Array rollover is reached with a 258-byte sequential read on the small device, and with a read across 0x1FF on the large one. Both sizes share one bus with different straps, so every acknowledge also shows that the other device stayed quiet.

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
  parameter bit BIG         = 1'b0,
  parameter int BUSY_CYCLES = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] strap_i,
  input  logic       wp_i
);
  localparam int AW    = BIG ? 9 : 8;
  localparam int DEPTH = 1 << AW;
  localparam int PAGE  = BIG ? 16 : 8;
  localparam int PW    = $clog2(PAGE);
  localparam int BW    = $clog2(BUSY_CYCLES + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_WORD, ST_WDAT, ST_RDAT} st_t;

  logic [2:0] scl_r, sda_r;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_r <= 3'b111;
      sda_r <= 3'b111;
    end else begin
      scl_r <= {scl_r[1:0], scl_i};
      sda_r <= {sda_r[1:0], sda_i};
    end

  logic scl_s, scl_q, sda_s, sda_q;
  assign scl_s = scl_r[1];
  assign scl_q = scl_r[2];
  assign sda_s = sda_r[1];
  assign sda_q = sda_r[2];

  logic scl_rise, scl_fall, start_det, stop_det;
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

  st_t            st, nst;
  logic [3:0]     cnt;
  logic           in_ack, mack, pg;
  logic [7:0]     sh;
  logic [AW-1:0]  addr;
  logic [PW-1:0]  woff;
  logic [PAGE-1:0] vld;
  logic [7:0]     pbuf [PAGE];
  logic [7:0]     mem  [DEPTH];
  logic [BW-1:0]  busy;

  logic [7:0] rd_byte;
  logic       busy_any, dev_hit;
  assign rd_byte  = mem[addr];
  assign busy_any = |busy;
  assign dev_hit  = (sh[7:4] == 4'b1010) && !busy_any &&
                    (BIG ? (sh[3:2] == strap_i[2:1]) : (sh[3:1] == strap_i));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st     <= ST_IDLE;
      nst    <= ST_IDLE;
      cnt    <= '0;
      in_ack <= 1'b0;
      mack   <= 1'b0;
      pg     <= 1'b0;
      sh     <= '0;
      addr   <= '0;
      woff   <= '0;
      vld    <= '0;
      busy   <= '0;
      sda_oe <= 1'b0;
      for (int i = 0; i < PAGE; i++) pbuf[i] <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (busy_any) busy <= busy - 1'b1;
      if (start_det) begin
        st     <= ST_ADDR;
        cnt    <= '0;
        in_ack <= 1'b0;
        sda_oe <= 1'b0;
        vld    <= '0;
      end else if (stop_det) begin
        if (|vld) begin
          for (int i = 0; i < PAGE; i++)
            if (vld[i]) mem[{addr[AW-1:PW], PW'(i)}] <= pbuf[i];
          busy <= BW'(BUSY_CYCLES);
          addr <= {addr[AW-1:PW], woff};
        end
        st     <= ST_IDLE;
        in_ack <= 1'b0;
        sda_oe <= 1'b0;
        vld    <= '0;
      end else if (st != ST_IDLE) begin
        if (scl_rise) begin
          if (in_ack) mack <= ~sda_s;
          else if (cnt != 4'd8) begin
            cnt <= cnt + 1'b1;
            if (st != ST_RDAT) sh <= {sh[6:0], sda_s};
          end
        end else if (scl_fall) begin
          if (in_ack) begin
            in_ack <= 1'b0;
            cnt    <= '0;
            sda_oe <= 1'b0;
            if (st == ST_RDAT ? mack : nst == ST_RDAT) begin
              st     <= ST_RDAT;
              sh     <= rd_byte;
              sda_oe <= ~rd_byte[7];
              addr   <= addr + 1'b1;
            end else st <= (st == ST_RDAT) ? ST_IDLE : nst;
          end else if (cnt == 4'd8) begin
            in_ack <= 1'b1;
            case (st)
              ST_ADDR:
                if (dev_hit) begin
                  sda_oe <= 1'b1;
                  if (BIG) pg <= sh[1];
                  nst <= sh[0] ? ST_RDAT : ST_WORD;
                end else nst <= ST_IDLE;
              ST_WORD: begin
                sda_oe <= 1'b1;
                addr   <= AW'({pg, sh});
                woff   <= sh[PW-1:0];
                nst    <= ST_WDAT;
              end
              ST_WDAT:
                if (!wp_i) begin
                  sda_oe     <= 1'b1;
                  pbuf[woff] <= sh;
                  vld[woff]  <= 1'b1;
                  woff       <= woff + 1'b1;
                  nst        <= ST_WDAT;
                end else nst <= ST_IDLE;
              default: sda_oe <= 1'b0;
            endcase
          end else if (st == ST_RDAT) begin
            sh     <= {sh[6:0], 1'b0};
            sda_oe <= ~sh[6];
          end
        end
      end
    end

  assert_oe_rise_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
  assert_idle_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe);
  assert_commit_on_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_any) |-> $past(stop_det));
  assert_no_ack_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ADDR && in_ack && sda_oe) |-> !busy_any);
  assert_wp_no_buffer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|vld) |-> !$past(wp_i));
endmodule

// File: tb/i2c_eeprom_slave_tb.sv
module i2c_eeprom_slave_tb_top;
  localparam int CLK_NS = 10;
  localparam int Q      = 4;
  localparam int BUSY   = 200;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic oe_a, oe_b, line;
  assign line = sda_m & ~oe_a & ~oe_b;
  always #(CLK_NS / 2) clk = ~clk;

  i2c_eeprom_slave #(.BIG(1'b0), .BUSY_CYCLES(BUSY)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(line), .sda_oe(oe_a),
    .strap_i(3'b101), .wp_i(wp));
  i2c_eeprom_slave #(.BIG(1'b1), .BUSY_CYCLES(BUSY)) dut512_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(line), .sda_oe(oe_b),
    .strap_i(3'b010), .wp_i(wp));

  int compared = 0, mismatched = 0;
  logic [7:0] m1 [256];
  logic [7:0] m2 [512];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    sda_m = b; tick(Q);
    scl_m = 1'b1; tick(Q);
    s = line; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(d[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input bit more, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      d[i] = s;
    end
    clk_bit(~more, s);
  endtask

  // page write; R3 acks, R5 wrap, R7 busy poll
  task automatic wr(input logic [7:0] dev, input logic [7:0] word, input int n,
                    input int seed, input bit big, input bit poll);
    logic ack;
    logic [7:0] v;
    int a;
    i2c_start();
    send_byte(dev, ack);  chk(ack, "R3 address ack", ack, 1);
    send_byte(word, ack); chk(ack, "R3 word ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      v = 8'((seed + 29 * k) & 255);
      send_byte(v, ack); chk(ack, "R3 data ack", ack, 1);
      if (big) begin
        a = (dev[1] ? 256 : 0) + (word & 8'hF0) + ((word + k) & 15);
        m2[a] = v;
      end else begin
        a = (word & 8'hF8) + ((word + k) & 7);
        m1[a] = v;
      end
    end
    i2c_stop();
    if (poll) begin
      i2c_start();
      send_byte(dev, ack); chk(!ack, "R7 busy refuses address", ack, 0);
      i2c_stop();
    end
    tick(BUSY + 20);
  endtask

  // random read then sequential; R4, R9
  task automatic rd(input logic [7:0] dev, input logic [7:0] word, input int n, input bit big);
    logic ack;
    logic [7:0] d;
    int a;
    i2c_start();
    send_byte(dev, ack);  chk(ack, "R4 address ack", ack, 1);
    send_byte(word, ack); chk(ack, "R4 word ack", ack, 1);
    i2c_start();
    send_byte(dev | 8'h01, ack); chk(ack, "R4 read address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, d);
      if (big) begin
        a = ((dev[1] ? 256 : 0) + word + k) % 512;
        chk(d == m2[a], "R9 R2 read data", d, m2[a]);
      end else begin
        a = (word + k) % 256;
        chk(d == m1[a], "R9 R4 read data", d, m1[a]);
      end
    end
    i2c_stop();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: run did not finish, got 0 expected 1");
    summary();
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] d;
    for (int i = 0; i < 256; i++) m1[i] = '0;
    for (int i = 0; i < 512; i++) m2[i] = '0;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    chk(!oe_a && !oe_b, "R11 reset releases line", {oe_a, oe_b}, 0);
    rd(8'hAA, 8'h00, 4, 1'b0);   // R11 zeros

    i2c_start(); send_byte(8'hAE, ack); chk(!ack, "R1 wrong strap", ack, 0); i2c_stop();
    i2c_start(); send_byte(8'hBA, ack); chk(!ack, "R1 wrong type code", ack, 0); i2c_stop();
    chk(!oe_a && !oe_b, "R1 silent after refusal", {oe_a, oe_b}, 0);

    for (int p = 0; p < 32; p++) wr(8'hAA, 8'(p * 8), 8, 29 * p * 8 + 11, 1'b0, p == 0);
    rd(8'hAA, 8'h00, 258, 1'b0);  // R9 rollover

    i2c_start();
    send_byte(8'hAB, ack); chk(ack, "R10 current read ack", ack, 1);
    recv_byte(1'b0, d); chk(d == m1[2], "R10 current address", d, m1[2]);
    i2c_stop();

    wr(8'hAA, 8'h15, 5, 200, 1'b0, 1'b0);  // R5 wrap
    wr(8'hAA, 8'h20, 10, 100, 1'b0, 1'b0); // R5 overwrite
    rd(8'hAA, 8'h10, 24, 1'b0);

    // R6 repeated start discards buffered data
    i2c_start();
    send_byte(8'hAA, ack); send_byte(8'h30, ack);
    send_byte(8'h55, ack); chk(ack, "R6 data ack", ack, 1);
    i2c_start();
    send_byte(8'hAB, ack);
    recv_byte(1'b0, d); chk(d == m1[8'h30], "R6 not stored", d, m1[8'h30]);
    i2c_stop();
    i2c_start(); send_byte(8'hAA, ack); chk(ack, "R6 no busy", ack, 1); i2c_stop();
    rd(8'hAA, 8'h30, 1, 1'b0);

    // R8 write protect
    wp = 1'b1;
    i2c_start();
    send_byte(8'hAA, ack); chk(ack, "R8 address ack", ack, 1);
    send_byte(8'h40, ack); chk(ack, "R8 word ack", ack, 1);
    send_byte(8'h99, ack); chk(!ack, "R8 data refused", ack, 0);
    i2c_stop();
    i2c_start();
    send_byte(8'hAA, ack); chk(ack, "R8 no busy", ack, 1);
    send_byte(8'h40, ack);
    i2c_start();
    send_byte(8'hAB, ack);
    recv_byte(1'b0, d); chk(d == m1[8'h40], "R8 unchanged", d, m1[8'h40]);
    i2c_stop();
    wp = 1'b0;

    // R2 512-byte device with page select
    wr(8'hA6, 8'h05, 3, 50, 1'b1, 1'b1);
    wr(8'hA4, 8'h05, 1, 70, 1'b1, 1'b0);
    rd(8'hA6, 8'h05, 3, 1'b1);
    rd(8'hA4, 8'h05, 1, 1'b1);
    wr(8'hA6, 8'hF0, 17, 90, 1'b1, 1'b0);  // R5 16-byte page wrap
    rd(8'hA6, 8'hF0, 18, 1'b1);            // R9 0x1FF -> 0x000

    summary();
    $finish;
  end
endmodule